// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block turns a 16-bit half-precision floating-point word into the 32-bit single-precision word of exactly the same value. No rounding ever happens because every half value fits in single precision. Zeros keep their sign. Normal values are rebiased. Subnormal halves are renormalised into single-precision normals. Infinities and NaNs map to their single-precision counterparts. A NaN output is always quiet. A separate flag reports when the incoming NaN was a signalling one.

A mode bit travels with each input word. With the mode clear, the largest exponent code means infinity or NaN. With it set, that code is an ordinary exponent, so the input covers magnitudes from 65536 up to 131008.

The block has valid/ready streams on both sides and a single output register stage. A word is taken when `in_valid` and `in_ready` are both high on a clock edge. Its result appears on the output from the next cycle. The result stays there unchanged until the consumer raises `out_ready`. The input accepts a new word whenever the stage is empty or is being drained in the same cycle, so the stream runs at full rate. Back-pressure reaches the producer with no delay.

Top module: `hwiden_top`

## Requirements
- R1: For a half exponent code e in 1..30, the output exponent field (bits 30:23) is e+112. The output fraction is the 10-bit half fraction placed in bits 22:13, with bits 12:0 zero.
- R2: An input with exponent 0 and fraction 0 gives an output whose bits 30:0 are all zero. Only the sign bit of the output carries the input sign.
- R3: For exponent 0 with a nonzero fraction, let z be the number of leading zeros of the 10-bit fraction. The output exponent is 112-z. The fraction bits below the leading one appear left-aligned in bits 22:13, and bits 12:0 are zero.
- R4: In standard mode (`in_alt_mode`=0), exponent 31 with fraction 0 gives an infinity: exponent field 0xFF and fraction 0.
- R5: In standard mode, exponent 31 with a nonzero fraction gives exponent field 0xFF with bit 22 forced to 1. Half fraction bits 8:0 land in bits 21:13, and bits 12:0 are zero.
- R6: `out_invalid` is 1 exactly when the input was a standard-mode NaN whose half fraction bit 9 was 0. It is 0 for every other input.
- R7: In alternative mode (`in_alt_mode`=1), exponent 31 is converted like R1, giving exponent field 143. For exponent codes 0..30 the mode has no effect.
- R8: `in_ready` is high when `out_valid` is low or `out_ready` is high. An input accepted on an edge shows its result with `out_valid`=1 after that edge. A held result that is consumed with no new input leaves `out_valid` low.
- R9: While `out_valid`=1 and `out_ready`=0, `out_single` and `out_invalid` hold their values and `in_ready` is 0.
- R10: While `rst_n` is low and after it rises, `out_valid` is 0 and `in_ready` is 1 until a word is accepted.
- R11: Output bit 31 equals input bit 15 for every class of input, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Block can take the offered word |
| in_half | input | 16 | Half-precision value: sign bit 15, exponent 14:10, fraction 9:0 |
| in_alt_mode | input | 1 | 1 treats exponent 31 as a normal exponent |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the held result |
| out_single | output | 32 | Single-precision result: sign 31, exponent 30:23, fraction 22:0 |
| out_invalid | output | 1 | The result came from a signalling NaN |

## Verification
The stream properties assume that `in_half` and `in_alt_mode` are known whenever `in_valid` is high. They also assume that reset is the only event that clears a held result. The bench changes every input on the falling clock edge and never leaves one unknown. It holds the offered word steady while back-pressure is applied. The reset-time checks are made only after the design has been held in reset for several cycles.

// File: rtl/hwiden_pkg.sv
package hwiden_pkg;
  localparam int H_EXP_W  = 5;
  localparam int H_FRAC_W = 10;
  localparam int H_W      = 1 + H_EXP_W + H_FRAC_W;
  localparam int S_EXP_W  = 8;
  localparam int S_FRAC_W = 23;
  localparam int S_W      = 1 + S_EXP_W + S_FRAC_W;
  localparam int H_BIAS   = (1 << (H_EXP_W - 1)) - 1;
  localparam int S_BIAS   = (1 << (S_EXP_W - 1)) - 1;
  localparam int REBIAS   = S_BIAS - H_BIAS;
  localparam int LZ_W     = $clog2(H_FRAC_W);

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUB,
    CL_NORM,
    CL_INF,
    CL_NAN
  } hclass_e;

  typedef struct packed {
    logic                sign;
    logic [H_EXP_W-1:0]  exp;
    logic [H_FRAC_W-1:0] frac;
  } half_t;

  typedef struct packed {
    logic                sign;
    logic [S_EXP_W-1:0]  exp;
    logic [S_FRAC_W-1:0] frac;
  } single_t;
endpackage

// File: rtl/hwiden_decode.sv
module hwiden_decode
  import hwiden_pkg::*;
(
  input  half_t   half_i,
  input  logic    alt_i,
  output hclass_e cls_o
);
  localparam logic [H_EXP_W-1:0] EXP_TOP = '1;

  always_comb begin
    if (half_i.exp == '0) begin
      cls_o = (half_i.frac == '0) ? CL_ZERO : CL_SUB;
    end else if (half_i.exp == EXP_TOP && !alt_i) begin
      cls_o = (half_i.frac == '0) ? CL_INF : CL_NAN;
    end else begin
      cls_o = CL_NORM;
    end
  end
endmodule

// File: rtl/hwiden_lead.sv
module hwiden_lead #(
  parameter int FW = 10,
  parameter int CW = $clog2(FW)
) (
  input  logic [FW-1:0] frac_i,
  output logic [CW-1:0] lz_o,
  output logic [FW-1:0] tail_o
);
  // The scan runs upward, so the highest set bit is the last to write.
  always_comb begin
    lz_o = '0;
    for (int i = 0; i < FW; i++) begin
      if (frac_i[i]) lz_o = CW'(FW - 1 - i);
    end
    tail_o = frac_i << (int'(lz_o) + 1);
  end
endmodule

// File: rtl/hwiden_assemble.sv
module hwiden_assemble
  import hwiden_pkg::*;
(
  input  half_t            half_i,
  input  hclass_e          cls_i,
  input  logic [LZ_W-1:0]  lz_i,
  input  logic [H_FRAC_W-1:0] tail_i,
  output single_t          res_o,
  output logic             snan_o
);
  localparam int PAD_W = S_FRAC_W - H_FRAC_W;
  localparam logic [S_EXP_W-1:0] EXP_MAX = '1;
  localparam logic [S_EXP_W-1:0] REB = S_EXP_W'(REBIAS);

  always_comb begin
    res_o.sign = half_i.sign;
    res_o.exp  = '0;
    res_o.frac = '0;
    snan_o     = 1'b0;
    unique case (cls_i)
      CL_ZERO: ;
      CL_SUB: begin
        res_o.exp  = REB - S_EXP_W'(lz_i);
        res_o.frac = {tail_i, {PAD_W{1'b0}}};
      end
      CL_NORM: begin
        res_o.exp  = S_EXP_W'(half_i.exp) + REB;
        res_o.frac = {half_i.frac, {PAD_W{1'b0}}};
      end
      CL_INF: begin
        res_o.exp  = EXP_MAX;
      end
      CL_NAN: begin
        res_o.exp  = EXP_MAX;
        res_o.frac = {1'b1, half_i.frac[H_FRAC_W-2:0], {PAD_W{1'b0}}};
        snan_o     = ~half_i.frac[H_FRAC_W-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hwiden_top.sv
module hwiden_top
  import hwiden_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [H_W-1:0] in_half,
  input  logic           in_alt_mode,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [S_W-1:0] out_single,
  output logic           out_invalid
);
  half_t               half_w;
  hclass_e             cls_w;
  logic [LZ_W-1:0]     lz_w;
  logic [H_FRAC_W-1:0] tail_w;
  single_t             res_w;
  logic                snan_w;
  logic                take_w;

  assign half_w = half_t'(in_half);

  hwiden_decode u_decode (
    .half_i (half_w),
    .alt_i  (in_alt_mode),
    .cls_o  (cls_w)
  );

  hwiden_lead #(.FW(H_FRAC_W), .CW(LZ_W)) u_lead (
    .frac_i (half_w.frac),
    .lz_o   (lz_w),
    .tail_o (tail_w)
  );

  hwiden_assemble u_asm (
    .half_i (half_w),
    .cls_i  (cls_w),
    .lz_i   (lz_w),
    .tail_i (tail_w),
    .res_o  (res_w),
    .snan_o (snan_w)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take_w   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_single  <= '0;
      out_invalid <= 1'b0;
    end else if (take_w) begin
      out_valid   <= 1'b1;
      out_single  <= res_w;
      out_invalid <= snan_w;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  localparam logic [S_EXP_W-1:0] SUB_EXP_LO = S_EXP_W'(REBIAS - (H_FRAC_W - 1));
  localparam logic [S_EXP_W-1:0] SUB_EXP_HI = S_EXP_W'(REBIAS);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> out_valid);

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_single) && $stable(out_invalid)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_snan_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_single[S_W-2 -: S_EXP_W] == '1 && out_single[S_FRAC_W-1]));

  p_sign_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (out_single[S_W-1] == $past(in_half[H_W-1])));

  p_sub_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && in_half[H_W-2 -: H_EXP_W] == '0 && in_half[H_FRAC_W-1:0] != '0) |=>
      (out_single[S_W-2 -: S_EXP_W] >= SUB_EXP_LO && out_single[S_W-2 -: S_EXP_W] <= SUB_EXP_HI));
endmodule

// File: tb/hwiden_top_tb_top.sv
module hwiden_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_half = '0;
  logic        in_alt_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_single;
  logic        out_invalid;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  hwiden_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_half(in_half), .in_alt_mode(in_alt_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_single(out_single), .out_invalid(out_invalid)
  );

  // Each entry: {mode, half input, expected single, expected invalid}
  localparam int NV = 21;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 16'h0000, 32'h00000000, 1'b0},
    {1'b0, 16'h8000, 32'h80000000, 1'b0},
    {1'b0, 16'h3C00, 32'h3F800000, 1'b0},
    {1'b0, 16'hC000, 32'hC0000000, 1'b0},
    {1'b0, 16'h7BFF, 32'h477FE000, 1'b0},
    {1'b0, 16'h0400, 32'h38800000, 1'b0},
    {1'b0, 16'h3555, 32'h3EAAA000, 1'b0},
    {1'b0, 16'h0001, 32'h33800000, 1'b0},
    {1'b0, 16'h03FF, 32'h387FC000, 1'b0},
    {1'b0, 16'h8200, 32'hB8000000, 1'b0},
    {1'b0, 16'h0055, 32'h36AA0000, 1'b0},
    {1'b0, 16'h7C00, 32'h7F800000, 1'b0},
    {1'b0, 16'hFC00, 32'hFF800000, 1'b0},
    {1'b0, 16'h7E00, 32'h7FC00000, 1'b0},
    {1'b0, 16'h7C01, 32'h7FC02000, 1'b1},
    {1'b0, 16'hFD55, 32'hFFEAA000, 1'b1},
    {1'b1, 16'h7C00, 32'h47800000, 1'b0},
    {1'b1, 16'h7FFF, 32'h47FFE000, 1'b0},
    {1'b1, 16'hFE00, 32'hC7C00000, 1'b0},
    {1'b1, 16'h3C00, 32'h3F800000, 1'b0},
    {1'b1, 16'h0001, 32'h33800000, 1'b0}
  };
  localparam string TAG [NV] = '{
    "R2", "R2 R11", "R1", "R1 R11", "R1", "R1", "R1", "R3", "R3", "R3 R11", "R3",
    "R4", "R4 R11", "R5 R6", "R5 R6", "R5 R6 R11", "R7 R6", "R7", "R7 R11", "R7", "R7"
  };

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic offer(input logic mode, input logic [15:0] h);
    in_alt_mode = mode;
    in_half     = h;
    in_valid    = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state during reset
    check("R10 reset valid/ready", {31'd0, out_valid, in_ready}, {31'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", {31'd0, out_valid, in_ready}, {31'd0, 1'b0, 1'b1});

    // Vector table, full-rate streaming with the consumer always ready (R8)
    out_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      offer(VEC[i][49], VEC[i][48:33]);
      @(negedge clk);
      check({TAG[i], " R8 valid"}, {32'd0, out_valid}, 33'd1);
      check(TAG[i], {out_single, out_invalid}, VEC[i][32:0]);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 drained", {32'd0, out_valid}, 33'd0);

    // R9: back-pressure holds the result and blocks the input
    out_ready = 1'b0;
    offer(1'b0, 16'h7C01);
    @(negedge clk);
    offer(1'b0, 16'h3C00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 held data", {out_single, out_invalid}, {32'h7FC02000, 1'b1});
      check("R9 in_ready low", {32'd0, in_ready}, 33'd0);
    end
    out_ready = 1'b1;
    #1;
    check("R8 ready follows out_ready", {32'd0, in_ready}, 33'd1);
    @(negedge clk);
    check("R8 second word after stall", {out_single, out_invalid}, {32'h3F800000, 1'b0});
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 empty after drain", {32'd0, out_valid}, 33'd0);

    // R6: signalling NaN pattern in alternative mode is not invalid
    offer(1'b1, 16'hFC01);
    @(negedge clk);
    check("R6 R7 alt no invalid", {out_single, out_invalid}, {32'hC7802000, 1'b0});
    in_valid = 1'b0;

    // R10: reset while a result is held
    out_ready = 1'b0;
    offer(1'b0, 16'h4000);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears valid", {31'd0, out_valid, in_ready}, {31'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 stays empty", {32'd0, out_valid}, 33'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule